// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Collector

This block gathers the interrupt events of eight DMA channels. Each channel raises single-cycle pulses for three kinds of event: half of a transfer done, a whole transfer done, and a transfer fault. Every pulse sets a sticky flag. The flag holds until software clears it. For each channel the block also derives a summary bit, which is set whenever any of that channel's three flags is set.

Software reaches the block through a plain word-wide port. A read at offset 0x0 returns the packed status word. A write at offset 0x4 is the clear word, and every 1 written there removes the matching flag. A channel's summary position in the clear word wipes all of that channel's flags at once.

Three enable vectors select which flags of each channel drive that channel's interrupt line. The line is registered and follows the flags and enables one clock later.

Top module: `dma_irq_flags`

## Requirements
- R1: While and after reset all status bits read 0 and every interrupt line is 0.
- R2: An event pulse on a channel sets its flag at the next clock edge. The flag stays set until it is cleared, and further pulses while it is set change nothing.
- R3: In the status word, channel c (0 to 7) owns bits 4c+3..4c: bit 4c+3 is the fault flag, 4c+2 the half flag, 4c+1 the done flag and 4c the summary bit.
- R4: The summary bit of a channel reads 1 exactly when at least one of its three flags is set.
- R5: A write at offset 0x4 clears every flag whose bit position, as in R3, holds a 1. Bits written as 0 leave their flags and all other channels unchanged.
- R6: A 1 at bit 4c of the clear word clears the fault, half and done flags of channel c together.
- R7: When an event pulse and a clear for the same flag arrive in the same cycle, the flag is set after that edge.
- R8: Writes at any offset other than 0x4 change no flag. Reads at any offset other than 0x0, the clear word included, return 0.
- R9: Interrupt line c is 1 in the cycle after a clock edge at which channel c had a set flag whose enable input was 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_half | input | 8 | Half-transfer event pulse per channel |
| evt_done | input | 8 | Transfer-complete event pulse per channel |
| evt_err | input | 8 | Transfer-error event pulse per channel |
| en_half | input | 8 | Half-transfer interrupt enable per channel |
| en_done | input | 8 | Transfer-complete interrupt enable per channel |
| en_err | input | 8 | Transfer-error interrupt enable per channel |
| bus_addr | input | 4 | Word offset of the access |
| bus_wr | input | 1 | Write strobe, one full word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 8 | Registered interrupt line per channel |

## Verification
The properties rely on the event, enable and bus inputs being known values that stay stable around each rising edge. They also rely on reset being released away from an edge, because each next-cycle property compares flags with the inputs sampled one edge earlier. The bench changes every input only on the falling clock edge, holds reset long enough for the flags to settle at zero, and keeps the bus address on defined offsets, with unmapped ones included. Its random phase mixes sparse event pulses with clear writes, so that event and clear often meet on the same flag in one cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  // Bit positions inside one channel nibble of the status and clear words
  localparam int NIB_W    = 4;
  localparam int NIB_GLB  = 0;
  localparam int NIB_DONE = 1;
  localparam int NIB_HALF = 2;
  localparam int NIB_ERR  = 3;

  typedef struct packed {
    logic err;
    logic half;
    logic done;
  } evt_t;

endpackage

// File: rtl/dma_irq_regif.sv
module dma_irq_regif
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int STAT_OFS = 0,
  parameter int CLR_OFS  = 4
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] bus_rdata,
  output evt_t              clr_o [NUM_CH]
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_OFS);

  logic clr_hit;
  logic stat_sel;

  always_comb begin
    clr_hit  = bus_wr && (bus_addr == CLR_A);
    stat_sel = (bus_addr == STAT_A);
  end

  // Read path: only the status word is readable, everything else is zero
  always_comb begin
    bus_rdata = stat_sel ? status_i : '0;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_clr
    logic wipe;
    always_comb begin
      wipe          = bus_wdata[NIB_W*c + NIB_GLB];
      clr_o[c].err  = clr_hit && (bus_wdata[NIB_W*c + NIB_ERR]  || wipe);
      clr_o[c].half = clr_hit && (bus_wdata[NIB_W*c + NIB_HALF] || wipe);
      clr_o[c].done = clr_hit && (bus_wdata[NIB_W*c + NIB_DONE] || wipe);
    end
  end

endmodule

// File: rtl/dma_irq_chan_flags.sv
module dma_irq_chan_flags
  import dma_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  evt_t evt_i,
  input  evt_t clr_i,
  output evt_t flag_o
);

  evt_t flag_q;
  evt_t flag_d;
  logic flag_en;

  // Event has priority over a clear in the same cycle
  always_comb begin
    flag_d  = (flag_q & ~clr_i) | evt_i;
    flag_en = (|evt_i) || (|clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/dma_irq_line.sv
module dma_irq_line
  import dma_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  evt_t flag_i,
  input  evt_t en_i,
  output logic irq_o
);

  logic irq_q;
  logic irq_d;
  logic irq_en;

  always_comb begin
    irq_d  = |(flag_i & en_i);
    irq_en = (irq_d != irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_en) begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int STAT_OFS = 0,
  parameter int CLR_OFS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_half,
  input  logic [NUM_CH-1:0] evt_done,
  input  logic [NUM_CH-1:0] evt_err,
  input  logic [NUM_CH-1:0] en_half,
  input  logic [NUM_CH-1:0] en_done,
  input  logic [NUM_CH-1:0] en_err,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  localparam int USED_W = NIB_W * NUM_CH;

  evt_t              clr_v  [NUM_CH];
  evt_t              flag_v [NUM_CH];
  logic [DATA_W-1:0] status_w;
  logic [NUM_CH-1:0] flag_half;
  logic [NUM_CH-1:0] flag_done;
  logic [NUM_CH-1:0] flag_err;

  dma_irq_regif #(
    .NUM_CH  (NUM_CH),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .STAT_OFS(STAT_OFS),
    .CLR_OFS (CLR_OFS)
  ) u_regif (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .status_i (status_w),
    .bus_rdata(bus_rdata),
    .clr_o    (clr_v)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    evt_t evt_c;
    evt_t en_c;

    always_comb begin
      evt_c.err  = evt_err[c];
      evt_c.half = evt_half[c];
      evt_c.done = evt_done[c];
      en_c.err   = en_err[c];
      en_c.half  = en_half[c];
      en_c.done  = en_done[c];
    end

    dma_irq_chan_flags u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (evt_c),
      .clr_i (clr_v[c]),
      .flag_o(flag_v[c])
    );

    dma_irq_line u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .flag_i(flag_v[c]),
      .en_i  (en_c),
      .irq_o (irq[c])
    );

    always_comb begin
      flag_half[c] = flag_v[c].half;
      flag_done[c] = flag_v[c].done;
      flag_err[c]  = flag_v[c].err;
      status_w[NIB_W*c + NIB_ERR]  = flag_v[c].err;
      status_w[NIB_W*c + NIB_HALF] = flag_v[c].half;
      status_w[NIB_W*c + NIB_DONE] = flag_v[c].done;
      status_w[NIB_W*c + NIB_GLB]  = |flag_v[c];
    end
  end

  if (DATA_W > USED_W) begin : g_pad
    assign status_w[DATA_W-1:USED_W] = '0;
  end

endmodule

// File: rtl/dma_irq_flags_chk.sv
module dma_irq_flags_chk #(
  parameter int NUM_CH   = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int STAT_OFS = 0,
  parameter int CLR_OFS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] evt_half,
  input logic [NUM_CH-1:0] evt_done,
  input logic [NUM_CH-1:0] evt_err,
  input logic [NUM_CH-1:0] en_half,
  input logic [NUM_CH-1:0] en_done,
  input logic [NUM_CH-1:0] en_err,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] flag_half,
  input logic [NUM_CH-1:0] flag_done,
  input logic [NUM_CH-1:0] flag_err
);

  // R2 and R7: a pulse always leaves its flag set, even against a clear
  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flag_half & $past(evt_half)) == $past(evt_half)) &&
              ((flag_done & $past(evt_done)) == $past(evt_done)) &&
              ((flag_err  & $past(evt_err))  == $past(evt_err))));

  // R2: no flag rises without a pulse
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flag_half & ~$past(flag_half) & ~$past(evt_half)) == '0) &&
              ((flag_done & ~$past(flag_done) & ~$past(evt_done)) == '0) &&
              ((flag_err  & ~$past(flag_err)  & ~$past(evt_err))  == '0)));

  // R8: non-status offsets read back zero
  p_other_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != ADDR_W'(STAT_OFS)) |-> (bus_rdata == '0));

  // R8: writes outside the clear offset never drop a flag
  p_stray_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == ADDR_W'(CLR_OFS))) |=>
      (((flag_half | flag_done | flag_err) & $past(flag_half | flag_done | flag_err))
        == $past(flag_half | flag_done | flag_err)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R4: summary bit seen at the read port matches its three flag bits
    p_summary_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(STAT_OFS)) |->
        (bus_rdata[4*c] == (|bus_rdata[4*c+3 -: 3])));

    // R6: summary-position clear with no pulse empties the channel
    p_wipe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == ADDR_W'(CLR_OFS)) && bus_wdata[4*c] &&
       !evt_half[c] && !evt_done[c] && !evt_err[c]) |=>
        (!flag_half[c] && !flag_done[c] && !flag_err[c]));

    // R9: line follows enabled flags one edge later
    p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq[c] == $past((flag_half[c] && en_half[c]) ||
                                (flag_done[c] && en_done[c]) ||
                                (flag_err[c]  && en_err[c]))));
  end

endmodule

bind dma_irq_flags dma_irq_flags_chk #(
  .NUM_CH  (NUM_CH),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .STAT_OFS(STAT_OFS),
  .CLR_OFS (CLR_OFS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_half (evt_half),
  .evt_done (evt_done),
  .evt_err  (evt_err),
  .en_half  (en_half),
  .en_done  (en_done),
  .en_err   (en_err),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq      (irq),
  .flag_half(flag_half),
  .flag_done(flag_done),
  .flag_err (flag_err)
);

// File: tb/test_dma_irq_flags.sv
`timescale 1ns/1ps
module test_dma_irq_flags;

  localparam int NCH = 8;
  localparam int DW  = 32;
  localparam int AW  = 4;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] evt_half, evt_done, evt_err;
  logic [NCH-1:0] en_half, en_done, en_err;
  logic [AW-1:0]  bus_addr;
  logic           bus_wr;
  logic [DW-1:0]  bus_wdata;
  logic [DW-1:0]  bus_rdata;
  logic [NCH-1:0] irq;

  logic [NCH-1:0] mh, md, me, irq_m;
  int checks;
  int fails;

  dma_irq_flags i_dma_irq_flags (
    .clk(clk), .rst_n(rst_n),
    .evt_half(evt_half), .evt_done(evt_done), .evt_err(evt_err),
    .en_half(en_half), .en_done(en_done), .en_err(en_err),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] pack(input logic [NCH-1:0] h, d, e);
    logic [DW-1:0] w;
    w = '0;
    for (int c = 0; c < NCH; c++) begin
      w[4*c+3] = e[c];
      w[4*c+2] = h[c];
      w[4*c+1] = d[c];
      w[4*c]   = h[c] | d[c] | e[c];
    end
    return w;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    evt_half = '0; evt_done = '0; evt_err = '0;
    bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = '0;
  endtask

  // Check current outputs, cross one rising edge, advance the model
  task automatic cyc();
    logic [NCH-1:0] ch, cd, ce;
    #1;
    if (bus_addr == 4'h0) chk("R3 R4 status word", bus_rdata, pack(mh, md, me));
    else                  chk("R8 read elsewhere", bus_rdata, '0);
    chk("R9 irq lines", {24'h0, irq}, {24'h0, irq_m});
    @(posedge clk);
    ch = '0; cd = '0; ce = '0;
    if (bus_wr && bus_addr == 4'h4) begin
      for (int c = 0; c < NCH; c++) begin
        ce[c] = bus_wdata[4*c+3] | bus_wdata[4*c];
        ch[c] = bus_wdata[4*c+2] | bus_wdata[4*c];
        cd[c] = bus_wdata[4*c+1] | bus_wdata[4*c];
      end
    end
    irq_m = (mh & en_half) | (md & en_done) | (me & en_err);
    mh = (mh & ~ch) | evt_half;
    md = (md & ~cd) | evt_done;
    me = (me & ~ce) | evt_err;
    @(negedge clk);
  endtask

  task automatic read_expect(input string tag, input logic [DW-1:0] exp);
    idle();
    #1;
    chk(tag, bus_rdata, exp);
    cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    mh = '0; md = '0; me = '0; irq_m = '0;
    rst_n = 1'b0;
    idle();
    en_half = '0; en_done = '0; en_err = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 status in reset", bus_rdata, '0);
    chk("R1 irq in reset", {24'h0, irq}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    read_expect("R1 status after reset", 32'h0);

    // R2 R3: fault pulse on channel 3 lands at bits 15 and 12
    idle(); evt_err[3] = 1'b1; cyc();
    read_expect("R3 fault ch3 nibble", 32'h0000_9000);
    // R2: repeated pulses keep one sticky flag
    idle(); evt_err[3] = 1'b1; cyc();
    idle(); evt_err[3] = 1'b1; cyc();
    read_expect("R2 sticky after repeats", 32'h0000_9000);

    // R5: writing zeros changes nothing
    idle(); bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h0; cyc();
    read_expect("R5 zero write", 32'h0000_9000);
    idle(); bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h0000_8000; cyc();
    read_expect("R5 single clear", 32'h0);

    // R5: clear only done of channel 0, half remains
    idle(); evt_half[0] = 1'b1; evt_done[0] = 1'b1; cyc();
    read_expect("R4 summary ch0", 32'h0000_0007);
    idle(); bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h0000_0002; cyc();
    read_expect("R5 partial clear", 32'h0000_0005);

    // R7: pulse and clear meet on half of channel 0
    idle(); evt_half[0] = 1'b1; bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h0000_0004; cyc();
    read_expect("R7 event wins", 32'h0000_0005);

    // R6: summary clear on channel 5
    idle(); evt_err[5] = 1'b1; evt_done[5] = 1'b1; cyc();
    read_expect("R6 before wipe", 32'h00B0_0005);
    idle(); bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h0010_0000; cyc();
    read_expect("R6 after wipe", 32'h0000_0005);

    // R8: write all ones to the status offset, then read clear offset
    idle(); bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'hFFFF_FFFF; cyc();
    read_expect("R8 status write ignored", 32'h0000_0005);
    idle(); bus_addr = 4'h4; #1; chk("R8 clear word reads zero", bus_rdata, 32'h0); cyc();

    // R9: enable half of channel 0, line rises one edge later
    idle(); en_half[0] = 1'b1; #1;
    chk("R9 irq before edge", {24'h0, irq}, 32'h0);
    cyc();
    #1; chk("R9 irq after edge", {24'h0, irq}, 32'h1);
    idle(); bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h0000_0001; cyc();
    cyc();
    #1; chk("R9 irq drops after clear", {24'h0, irq}, 32'h0);
    cyc();

    // Random phase
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      idle();
      evt_half = NCH'($urandom & $urandom & $urandom);
      evt_done = NCH'($urandom & $urandom & $urandom);
      evt_err  = NCH'($urandom & $urandom & $urandom);
      if (($urandom % 4) == 0) begin
        bus_wr    = 1'b1;
        bus_wdata = $urandom & $urandom;
      end
      case ($urandom % 3)
        0: bus_addr = 4'h0;
        1: bus_addr = 4'h4;
        default: bus_addr = 4'h8;
      endcase
      if (($urandom % 16) == 0) begin
        en_half = NCH'($urandom);
        en_done = NCH'($urandom);
        en_err  = NCH'($urandom);
      end
      cyc();
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule